// File: doc/BRIEF.md
# Serial Flash Status Register and Write-Protect Guard

This block keeps the status byte of a small serial flash and decides which modifying operations may proceed. The command front-end hands it decoded requests (set or clear the write-enable latch, read the status, write the status) together with the data byte of a status write. The program/erase sequencer asks it for permission before each program or erase and reports back through busy and done signals. A query port tells any other logic whether a given byte address lies in the protected region. The write-protect pin is sampled through a synchronizer. When the pin is low and the status-lock bit is set, the status byte is frozen.

A status write does not take effect at once. It runs a self-timed cycle whose length is a parameter, and the in-progress bit stays set for that whole cycle. The protection bits are kept in ordinary flops and stand in for the nonvolatile cells. A refused request drops the write-enable latch. A request that arrives while an operation is in progress is simply dropped, and nothing changes.

Top module: `flash_sr_guard`

## Requirements
- R1: After reset, status_byte is 00h and pe_grant, pe_deny and chk_prot are 0.
- R2: Opcode 06h on cmd_op with cmd_valid sets the write-enable bit, seen one cycle later. Opcode 04h clears it. Both act even while the in-progress bit is 1.
- R3: The status_byte layout is: bit 7 is the status-lock bit, bits 3:2 are the two protect-level bits, bit 1 is write-enable and bit 0 is in-progress. Bits 6:4 always read 0, whatever data is written.
- R4: chk_prot reflects chk_addr one cycle later. Protect level 0 protects no address. Level 1 protects only the upper 64 KB block (address bit 16 set, 010000h to 01FFFFh). Levels 2 and 3 protect every address. The same rule gates pe_req at pe_addr.
- R5: Opcode 01h with the write-enable bit set, no lock and no operation in progress starts a status write. The in-progress bit is 1 for WRSR_CYC cycles. After that, data bit 7 and bits 3:2 are loaded into the status-lock and protect-level bits, and write-enable returns to 0.
- R6: A status write is refused when the write-enable bit is 0, or when the status-lock bit is 1 while the synchronized wp_n is low. A refusal changes no status bit except that it clears write-enable.
- R7: pe_req with write-enable set, nothing in progress and an unprotected pe_addr gives a one-cycle pe_grant pulse one cycle later. The in-progress bit is then 1 until pe_done, which clears both the in-progress bit and write-enable.
- R8: pe_req with nothing in progress but with write-enable 0 or a protected pe_addr gives a one-cycle pe_deny pulse one cycle later and clears write-enable.
- R9: While the in-progress bit is 1, status writes and pe_req are ignored. There is no grant, no deny, no change to any status bit and no status write later.
- R10: pe_busy high sets the in-progress bit one cycle later. The bit is held as long as pe_busy stays high.
- R11: Any opcode other than 06h, 04h and 01h (read-status 05h included) leaves status_byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_op | input | 8 | Command opcode |
| cmd_data | input | 8 | Data byte of a status write |
| wp_n | input | 1 | Write-protect pin, active low, asynchronous |
| pe_req | input | 1 | Program/erase permission request |
| pe_addr | input | ADDR_W | Target address of the request |
| pe_busy | input | 1 | Sequencer busy level |
| pe_done | input | 1 | Sequencer completion pulse |
| chk_addr | input | ADDR_W | Address for the protection query |
| status_byte | output | 8 | Current status byte |
| pe_grant | output | 1 | Request accepted, one-cycle pulse |
| pe_deny | output | 1 | Request refused, one-cycle pulse |
| chk_prot | output | 1 | chk_addr is protected |

## Verification
The bench builds the block with WRSR_CYC set to 4, which keeps the whole status-write window inside a handful of cycles. This allows the in-progress bit to be checked both during and after the window, and requests issued inside it to be checked as ignored. SYNC_STAGES is 2, so a change on wp_n takes effect within three cycles. ADDR_W is 17 and BLK_W is 16, which places the protected block at address bit 16 and puts both sides of the 010000h boundary in the protection table.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;
  localparam logic [7:0] OP_WEN_SET = 8'h06;
  localparam logic [7:0] OP_WEN_CLR = 8'h04;
  localparam logic [7:0] OP_SR_READ = 8'h05;
  localparam logic [7:0] OP_SR_LOAD = 8'h01;

  localparam int BIT_LOCK = 7;
  localparam int BIT_LVL_HI = 3;
  localparam int BIT_LVL_LO = 2;
  localparam int BIT_WEN = 1;
  localparam int BIT_BUSY = 0;

  typedef struct packed {
    logic       lock;
    logic [1:0] lvl;
    logic       wen;
    logic       busy;
  } sr_state_t;

  function automatic logic [7:0] pack_sr(input sr_state_t s);
    logic [7:0] b;
    b = 8'h00;
    b[BIT_LOCK] = s.lock;
    b[BIT_LVL_HI:BIT_LVL_LO] = s.lvl;
    b[BIT_WEN] = s.wen;
    b[BIT_BUSY] = s.busy;
    return b;
  endfunction
endpackage

// File: rtl/sr_wp_sync.sv
module sr_wp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic level
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign level = chain[STAGES-1];
endmodule

// File: rtl/sr_prot_map.sv
module sr_prot_map #(
  parameter int ADDR_W = 17,
  parameter int BLK_W  = 16
) (
  input  logic [1:0]        lvl,
  input  logic [ADDR_W-1:0] addr,
  output logic              prot
);
  localparam int TOP_W = ADDR_W - BLK_W;

  logic [TOP_W-1:0] blk_idx;
  logic             in_top_blk;

  assign blk_idx    = addr[ADDR_W-1:BLK_W];
  assign in_top_blk = &blk_idx;

  always_comb begin
    case (lvl)
      2'd0:    prot = 1'b0;
      2'd1:    prot = in_top_blk;
      default: prot = 1'b1;
    endcase
  end
endmodule

// File: rtl/sr_wr_timer.sv
module sr_wr_timer #(
  parameter int CYC = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] din,
  output logic       active,
  output logic       commit,
  output logic [7:0] dout
);
  localparam int CNT_W = $clog2(CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CYC);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  assign commit = active && (cnt == CNT_ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      dout   <= 8'h00;
    end else if (start && !active) begin
      active <= 1'b1;
      cnt    <= CNT_LOAD;
      dout   <= din;
    end else if (active) begin
      if (cnt == CNT_ONE) active <= 1'b0;
      cnt <= cnt - CNT_ONE;
    end
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt >= CNT_ONE && cnt <= CNT_LOAD)); // R5
  AST_TIMER_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active)) |-> $stable(dout)); // R5
endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
  import flash_sr_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int BLK_W       = 16,
  parameter int WRSR_CYC    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [7:0]        cmd_data,
  input  logic              wp_n,
  input  logic              pe_req,
  input  logic [ADDR_W-1:0] pe_addr,
  input  logic              pe_busy,
  input  logic              pe_done,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic [7:0]        status_byte,
  output logic              pe_grant,
  output logic              pe_deny,
  output logic              chk_prot
);
  logic       lock_q;
  logic [1:0] lvl_q;
  logic       wen_q;
  logic       op_active_q;
  logic       busy_q;
  logic       wp_lvl;
  logic       req_prot;
  logic       chk_p;
  logic       wr_active;
  logic       wr_commit;
  logic [7:0] wr_data;
  logic       wip;
  logic       wr_lock;
  logic       is_wen_set, is_wen_clr, wr_try, wr_start, wr_refuse;
  logic       pe_try, pe_ok, pe_bad;
  sr_state_t  st;

  sr_wp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_n(wp_n), .level(wp_lvl));

  sr_prot_map #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_map_req (
    .lvl(lvl_q), .addr(pe_addr), .prot(req_prot));

  sr_prot_map #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_map_chk (
    .lvl(lvl_q), .addr(chk_addr), .prot(chk_p));

  sr_wr_timer #(.CYC(WRSR_CYC)) u_timer (
    .clk(clk), .rst(rst), .start(wr_start), .din(cmd_data),
    .active(wr_active), .commit(wr_commit), .dout(wr_data));

  assign wip        = op_active_q | busy_q | wr_active;
  assign wr_lock    = lock_q & ~wp_lvl;
  assign is_wen_set = cmd_valid && (cmd_op == OP_WEN_SET);
  assign is_wen_clr = cmd_valid && (cmd_op == OP_WEN_CLR);
  assign wr_try     = cmd_valid && (cmd_op == OP_SR_LOAD) && !wip;
  assign wr_start   = wr_try && wen_q && !wr_lock;
  assign wr_refuse  = wr_try && !wr_start;
  assign pe_try     = pe_req && !wip && !wr_try;
  assign pe_ok      = pe_try && wen_q && !req_prot;
  assign pe_bad     = pe_try && !pe_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q      <= 1'b0;
      lvl_q       <= 2'b00;
      wen_q       <= 1'b0;
      op_active_q <= 1'b0;
      busy_q      <= 1'b0;
      pe_grant    <= 1'b0;
      pe_deny     <= 1'b0;
      chk_prot    <= 1'b0;
    end else begin
      busy_q   <= pe_busy;
      pe_grant <= pe_ok;
      pe_deny  <= pe_bad;
      chk_prot <= chk_p;
      if (pe_ok)        op_active_q <= 1'b1;
      else if (pe_done) op_active_q <= 1'b0;
      if (wr_commit) begin
        lock_q <= wr_data[BIT_LOCK];
        lvl_q  <= wr_data[BIT_LVL_HI:BIT_LVL_LO];
      end
      if (is_wen_set)
        wen_q <= 1'b1;
      else if (is_wen_clr || wr_commit || pe_done || wr_refuse || pe_bad)
        wen_q <= 1'b0;
    end
  end

  always_comb begin
    st.lock = lock_q;
    st.lvl  = lvl_q;
    st.wen  = wen_q;
    st.busy = wip;
    status_byte = pack_sr(st);
  end

  AST_GRANT_NEEDS_WEN: assert property (@(posedge clk) disable iff (rst)
    pe_grant |-> ($past(wen_q) && !$past(wip))); // R7
  AST_GRANT_UNPROT: assert property (@(posedge clk) disable iff (rst)
    pe_grant |-> !$past(req_prot)); // R4
  AST_WIP_BLOCKS_PE: assert property (@(posedge clk) disable iff (rst)
    wip |=> (!pe_grant && !pe_deny)); // R9
  AST_HW_LOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_active) |-> !$past(wr_lock)); // R6
  AST_SR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_commit) |-> $stable({lock_q, lvl_q})); // R5
  AST_DONE_CLR: assert property (@(posedge clk) disable iff (rst)
    (pe_done && !is_wen_set) |=> !wen_q); // R7
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pe_grant, pe_deny})); // R8
endmodule

// File: tb/sim_flash_sr_guard.sv
module sim_flash_sr_guard;
  localparam int CLK_P = 10;
  localparam int AW = 17;
  localparam int WR_T = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_op = 8'h00;
  logic [7:0] cmd_data = 8'h00;
  logic wp_n = 1'b1;
  logic pe_req = 1'b0;
  logic [AW-1:0] pe_addr = '0;
  logic pe_busy = 1'b0;
  logic pe_done = 1'b0;
  logic [AW-1:0] chk_addr = '0;
  logic [7:0] status_byte;
  logic pe_grant, pe_deny, chk_prot;

  int checks = 0;
  int errors = 0;
  logic [1:0] cur_lvl = 2'd0;

  always #(CLK_P/2) clk = ~clk;

  flash_sr_guard #(.ADDR_W(AW), .BLK_W(16), .WRSR_CYC(WR_T), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .wp_n(wp_n), .pe_req(pe_req), .pe_addr(pe_addr), .pe_busy(pe_busy), .pe_done(pe_done),
    .chk_addr(chk_addr), .status_byte(status_byte), .pe_grant(pe_grant), .pe_deny(pe_deny),
    .chk_prot(chk_prot));

  // {level[1:0], address[16:0], expected protect}
  localparam logic [19:0] PTAB [12] = '{
    {2'd0, 17'h00000, 1'b0}, {2'd0, 17'h1FFFF, 1'b0},
    {2'd1, 17'h0FFFF, 1'b0}, {2'd1, 17'h10000, 1'b1},
    {2'd1, 17'h1FFFF, 1'b1}, {2'd1, 17'h00000, 1'b0},
    {2'd2, 17'h00000, 1'b1}, {2'd2, 17'h0ABCD, 1'b1},
    {2'd3, 17'h1ABCD, 1'b1}, {2'd3, 17'h00123, 1'b1},
    {2'd0, 17'h10000, 1'b0}, {2'd0, 17'h0FFFF, 1'b0}};

  function automatic logic [7:0] mk(input logic lk, input logic [1:0] lv,
                                    input logic we, input logic bz);
    return {lk, 3'b000, lv, we, bz};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 8'h00;
  endtask

  task automatic pe(input logic [AW-1:0] a);
    pe_req = 1'b1; pe_addr = a;
    @(negedge clk);
    pe_req = 1'b0;
  endtask

  task automatic set_sr(input logic [7:0] v);
    cmd(8'h06, 8'h00);
    cmd(8'h01, v);
    idle(WR_T);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    check("R1 status", status_byte, 8'h00);
    check("R1 grant", pe_grant, 0);
    check("R1 deny", pe_deny, 0);
    check("R1 chk", chk_prot, 0);
    // R2 set / clear write-enable
    cmd(8'h06, 8'h00);
    check("R2 set", status_byte, mk(0, 0, 1, 0));
    // R11 read-status and unknown opcode leave state alone
    cmd(8'h05, 8'h00);
    check("R11 read", status_byte, mk(0, 0, 1, 0));
    cmd(8'hAB, 8'hFF);
    check("R11 other", status_byte, mk(0, 0, 1, 0));
    cmd(8'h04, 8'h00);
    check("R2 clr", status_byte, mk(0, 0, 0, 0));
    // R6 status write without write-enable
    cmd(8'h01, 8'h8C);
    check("R6 nowen busy", status_byte, mk(0, 0, 0, 0));
    idle(WR_T + 1);
    check("R6 nowen after", status_byte, mk(0, 0, 0, 0));
    // R5 accepted status write
    cmd(8'h06, 8'h00);
    cmd(8'h01, 8'h8C);
    check("R5 wip start", status_byte, mk(0, 0, 1, 1));
    idle(WR_T - 1);
    check("R5 wip last", status_byte, mk(0, 0, 1, 1));
    idle(1);
    check("R5 commit", status_byte, mk(1, 3, 0, 0));
    // R3 reserved bits stay zero
    set_sr(8'hFF);
    check("R3 layout", status_byte, 8'h8C);
    // R6 hardware lock
    wp_n = 1'b0;
    idle(3);
    cmd(8'h06, 8'h00);
    check("R6 wen", status_byte, mk(1, 3, 1, 0));
    cmd(8'h01, 8'h00);
    check("R6 locked", status_byte, mk(1, 3, 0, 0));
    idle(WR_T + 1);
    check("R6 locked after", status_byte, mk(1, 3, 0, 0));
    wp_n = 1'b1;
    idle(3);
    set_sr(8'h00);
    check("R6 unlocked", status_byte, mk(0, 0, 0, 0));
    // R4 protection table
    for (int i = 0; i < 12; i++) begin
      if (PTAB[i][19:18] != cur_lvl) begin
        set_sr({4'b0000, PTAB[i][19:18], 2'b00});
        cur_lvl = PTAB[i][19:18];
      end
      chk_addr = PTAB[i][17:1];
      @(negedge clk);
      check($sformatf("R4 prot lvl%0d addr%0h", cur_lvl, chk_addr), chk_prot, PTAB[i][0]);
    end
    // R7 grant with level 1
    set_sr(8'h04);
    cmd(8'h06, 8'h00);
    pe(17'h00100);
    check("R7 grant", {pe_grant, pe_deny}, 2'b10);
    check("R7 wip", status_byte, mk(0, 1, 1, 1));
    idle(1);
    check("R7 pulse", pe_grant, 0);
    // R9 ignored while in progress
    pe(17'h00200);
    check("R9 pe ignored", {pe_grant, pe_deny}, 2'b00);
    cmd(8'h01, 8'h00);
    idle(WR_T + 1);
    check("R9 sr ignored", status_byte, mk(0, 1, 1, 1));
    cmd(8'h04, 8'h00);
    check("R9 wen clr", status_byte, mk(0, 1, 0, 1));
    cmd(8'h06, 8'h00);
    check("R9 wen set", status_byte, mk(0, 1, 1, 1));
    pe_done = 1'b1;
    @(negedge clk);
    pe_done = 1'b0;
    check("R7 done", status_byte, mk(0, 1, 0, 0));
    // R8 denies
    pe(17'h00000);
    check("R8 nowen", {pe_grant, pe_deny}, 2'b01);
    cmd(8'h06, 8'h00);
    pe(17'h10000);
    check("R8 prot", {pe_grant, pe_deny}, 2'b01);
    check("R8 wen cleared", status_byte, mk(0, 1, 0, 0));
    // R10 sequencer busy
    pe_busy = 1'b1;
    @(negedge clk);
    check("R10 busy", status_byte, mk(0, 1, 0, 1));
    cmd(8'h06, 8'h00);
    pe(17'h00000);
    check("R9 busy ignored", {pe_grant, pe_deny}, 2'b00);
    check("R10 held", status_byte, mk(0, 1, 1, 1));
    pe_busy = 1'b0;
    @(negedge clk);
    check("R10 release", status_byte, mk(0, 1, 1, 0));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule